// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes and moves them forward by one second for every 2^DIV_W pulses of a clock-enable input. With the default DIV_W of 15 and an enable that pulses at 32.768 kHz, that is one step per second. It holds seven byte fields: seconds, minutes, hours, day of week, date, month with a century flag, and year. The hour byte can be set to 12-hour or 24-hour format.

A host changes the time through a byte-wide write strobe. A write to the seconds byte also restarts the sub-second divider, so the next step comes exactly one full second later. Reads come from a seven-byte snapshot rather than from the live fields. The snapshot is refreshed on a bus START and whenever the read pointer wraps from the last byte back to byte 0. This keeps a multi-byte read consistent while the clock keeps running. A 1 Hz square wave marks the second half of each divider period. The block does not check for illegal values written by the host.

Top module: `bcd_calendar`

## Requirements
- R1: A synchronous reset loads byte 0 (seconds) = 00, byte 1 (minutes) = 00, byte 2 (hours) = 00, byte 3 (day of week) = 01, byte 4 (date) = 01, byte 5 (month) = 01 with century bit 7 = 0, and byte 6 (year) = 00.
- R2: Seconds (byte 0) and minutes (byte 1) count in BCD from 00 to 59. Each returns from 59 to 00 and carries into the next field in the same step.
- R3: When hour bit 6 is 0 (24-hour format), bits 5:0 hold a BCD hour from 00 to 23. The hour returns from 23 to 00 and starts a new day.
- R4: When hour bit 6 is 1 (12-hour format), bit 5 is the PM flag (1 = PM) and bits 4:0 hold a BCD hour from 01 to 12. Hour 11 goes to 12 and toggles the PM flag. Hour 12 goes to 01 and keeps the flag. Going from 11 PM to 12 AM starts a new day.
- R5: The day of week (byte 3) steps at each new day and wraps from 7 back to 1.
- R6: The date (byte 4) returns to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for all other months except February. February ends on 28, or on 29 when the two BCD year digits form a number divisible by 4. The century flag plays no part in this.
- R7: The month (bits 4:0 of byte 5) returns from 12 to 01 and carries into the year (byte 6). When the year goes from 99 to 00, bit 7 of byte 5 toggles.
- R8: When wr_en is high, wr_data replaces the byte selected by wr_addr, and no time step happens in that cycle. A write to byte 0 clears the divider, so the next step arrives after exactly 2^DIV_W more enable pulses.
- R9: sqw_1hz is low right after a seconds write. It rises once 2^(DIV_W-1) enable pulses have been counted after that write, which is half a second.
- R10: A snap_start pulse copies all seven live bytes into the snapshot. Reads show that copy and ignore any later change to the live fields.
- R11: rd_set loads the read pointer from rd_addr, and rd_next advances it. rd_data shows the snapshot byte at the pointer one clock after the pointer updates. rd_next at byte 6 wraps the pointer to byte 0 and refreshes the snapshot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Divider enable, one pulse per oscillator period |
| wr_en | input | 1 | Write strobe for one byte, applied on the byte acknowledge |
| wr_addr | input | ADDR_W | Index of the byte to write (0 to 6) |
| wr_data | input | 8 | BCD value to write |
| snap_start | input | 1 | Bus START: refreshes the snapshot |
| rd_set | input | 1 | Loads the read pointer from rd_addr |
| rd_addr | input | ADDR_W | New read pointer value |
| rd_next | input | 1 | Advances the read pointer |
| rd_data | output | 8 | Snapshot byte at the read pointer, registered |
| sqw_1hz | output | 1 | Square wave, high during the second half of each second |

## Verification
The bench steers the counter onto its rollover edges. It tests 23:59:59 and the 11 and 12 o'clock transitions in both hour formats, the last day of 30-day and 31-day months, and February in leap years, in ordinary years and in year 00. It also tests 31 December of year 99. A design with a wrong month-length table or leap test would land on the 29th, 30th or 31st when it should show the first of the next month. A design that toggled the PM flag on the wrong hour, or started the new day at 12 noon, would put the AM/PM bit and the weekday out of step with the bench model. A divider that is not cleared by a seconds write shows up as a seconds byte that steps early, or as a square wave that rises at the wrong enable count. A snapshot that follows the live fields shows up as a byte 0 value that changes with no START or pointer wrap.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NFIELD = 7;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DOW  = 3'd3,
    F_DATE = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } field_e;

  // Add one to a two-digit packed BCD value (no upper bound check).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Year digits divisible by 4: even tens need ones 0/4/8, odd tens need 2/6.
  function automatic logic year_is_leap(input logic [7:0] yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  // Last date of a month, in BCD.
  function automatic logic [7:0] month_last(input logic [4:0] mon, input logic leap);
    case (mon)
      5'h02:                      return leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
  parameter int DIV_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic clr,
  output logic sec_tick,
  output logic half_phase
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;
  end

  assign sec_tick   = tick_en && !clr && (cnt == {DIV_W{1'b1}});
  assign half_phase = cnt[DIV_W-1];
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step
  import cal_pkg::*;
(
  input  logic [7:0] hour_q,
  output logic [7:0] hour_nx,
  output logic       day_carry
);
  logic [7:0] inc12;
  logic [7:0] inc24;

  always_comb begin
    inc12     = bcd_inc({3'b000, hour_q[4:0]});
    inc24     = bcd_inc({2'b00, hour_q[5:0]});
    hour_nx   = hour_q;
    day_carry = 1'b0;
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h12) begin
        hour_nx = {hour_q[7:5], 5'h01};
      end else if (hour_q[4:0] == 5'h11) begin
        hour_nx   = {hour_q[7:6], ~hour_q[5], 5'h12};
        day_carry = hour_q[5];
      end else begin
        hour_nx = {hour_q[7:5], inc12[4:0]};
      end
    end else begin
      if (hour_q[5:0] == 6'h23) begin
        hour_nx   = {hour_q[7:6], 6'h00};
        day_carry = 1'b1;
      end else begin
        hour_nx = {hour_q[7:6], inc24[5:0]};
      end
    end
  end
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper
  import cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sec_tick,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  output logic [NFIELD-1:0][7:0]       fields
);
  logic [7:0] sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
  logic [7:0] hour_nx;
  logic       hour_carry;
  logic       sec_wrap, min_wrap, day_wrap, date_wrap, mon_wrap, year_wrap;
  logic [7:0] last_date;

  cal_hour_step u_hour (
    .hour_q   (hour_q),
    .hour_nx  (hour_nx),
    .day_carry(hour_carry)
  );

  always_comb begin
    last_date = month_last(mon_q[4:0], year_is_leap(year_q));
    sec_wrap  = (sec_q == 8'h59);
    min_wrap  = sec_wrap && (min_q == 8'h59);
    day_wrap  = min_wrap && hour_carry;
    date_wrap = day_wrap && (date_q == last_date);
    mon_wrap  = date_wrap && (mon_q[4:0] == 5'h12);
    year_wrap = mon_wrap && (year_q == 8'h99);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(F_SEC):  sec_q  <= wr_data;
        ADDR_W'(F_MIN):  min_q  <= wr_data;
        ADDR_W'(F_HOUR): hour_q <= wr_data;
        ADDR_W'(F_DOW):  dow_q  <= wr_data;
        ADDR_W'(F_DATE): date_q <= wr_data;
        ADDR_W'(F_MON):  mon_q  <= wr_data;
        ADDR_W'(F_YEAR): year_q <= wr_data;
        default: ;
      endcase
    end else if (sec_tick) begin
      sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (sec_wrap) min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
      if (min_wrap) hour_q <= hour_nx;
      if (day_wrap) begin
        dow_q  <= (dow_q == 8'h07) ? 8'h01 : bcd_inc(dow_q);
        date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
      end
      if (date_wrap) mon_q <= {mon_q[7] ^ year_wrap, mon_q[6:5],
                               mon_wrap ? 5'h01 : bcd_inc({3'b000, mon_q[4:0]})[4:0]};
      if (mon_wrap) year_q <= year_wrap ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign fields = {year_q, mon_q, date_q, dow_q, hour_q, min_q, sec_q};
endmodule

// File: rtl/cal_snapshot.sv
module cal_snapshot
  import cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   snap_start,
  input  logic [NFIELD-1:0][7:0] live,
  input  logic                   rd_set,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic                   rd_next,
  output logic                   load_all,
  output logic [7:0]             rd_data
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NFIELD - 1);

  logic [NFIELD-1:0][7:0] snap;
  logic [ADDR_W-1:0]      ptr;
  logic                   wrap_load;

  assign wrap_load = rd_next && !rd_set && (ptr == LAST);
  assign load_all  = snap_start || wrap_load;

  for (genvar i = 0; i < NFIELD; i++) begin : g_snap
    always_ff @(posedge clk) begin
      if (rst)           snap[i] <= 8'h00;
      else if (load_all) snap[i] <= live[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (rd_set) begin
      ptr <= (rd_addr > LAST) ? '0 : rd_addr;
    end else if (rd_next) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= snap[ptr];
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              snap_start,
  input  logic              rd_set,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_next,
  output logic [7:0]        rd_data,
  output logic              sqw_1hz
);
  logic                   sec_clr;
  logic                   sec_tick;
  logic                   snap_load;
  logic [NFIELD-1:0][7:0] live;

  assign sec_clr = wr_en && (wr_addr == ADDR_W'(F_SEC));

  cal_divider #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .clr       (sec_clr),
    .sec_tick  (sec_tick),
    .half_phase(sqw_1hz)
  );

  cal_timekeeper #(.ADDR_W(ADDR_W)) u_time (
    .clk     (clk),
    .rst     (rst),
    .sec_tick(sec_tick),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .fields  (live)
  );

  cal_snapshot #(.ADDR_W(ADDR_W)) u_snap (
    .clk       (clk),
    .rst       (rst),
    .snap_start(snap_start),
    .live      (live),
    .rd_set    (rd_set),
    .rd_addr   (rd_addr),
    .rd_next   (rd_next),
    .load_all  (snap_load),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/cal_checks.sv
module cal_checks
  import cal_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic [7:0]             wr_data,
  input logic                   sec_tick,
  input logic                   sqw_1hz,
  input logic [NFIELD-1:0][7:0] live
);
  // R2: seconds return to 00 after 59
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && live[0] == 8'h59) |=> (live[0] == 8'h00));

  // R5: weekday always within 1..7
  assert_dow_range_R5: assert property (@(posedge clk) disable iff (rst)
    (live[3] >= 8'h01 && live[3] <= 8'h07));

  // R7: century bit changes only on a year wrap or a month write
  assert_century_R7: assert property (@(posedge clk) disable iff (rst)
    (live[5][7] != $past(live[5][7])) |->
      ($past(wr_en && wr_addr == ADDR_W'(F_MON)) ||
       ($past(live[6]) == 8'h99 && live[6] == 8'h00)));

  // R8: written seconds value lands in the live field
  assert_sec_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(F_SEC)) |=> (live[0] == $past(wr_data)));

  // R9: square wave is low right after a seconds write
  assert_sqw_restart_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(F_SEC)) |=> !sqw_1hz);
endmodule

bind bcd_calendar cal_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .sec_tick(sec_tick),
  .sqw_1hz (sqw_1hz),
  .live    (live)
);

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
module sim_bcd_calendar;
  localparam int DIV_W = 3;
  localparam int PER_SEC = 1 << DIV_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic       snap_start = 1'b0;
  logic       rd_set = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic       rd_next = 1'b0;
  logic [7:0] rd_data;
  logic       sqw_1hz;

  int checks = 0;
  int errors = 0;
  logic [7:0] rb [0:6];

  int e_sec, e_min, e_hr, e_m12, e_dow, e_date, e_mon, e_year, e_cent;

  always #2 clk = ~clk;

  bcd_calendar #(.DIV_W(DIV_W), .ADDR_W(3)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .snap_start(snap_start), .rd_set(rd_set), .rd_addr(rd_addr),
    .rd_next(rd_next), .rd_data(rd_data), .sqw_1hz(sqw_1hz)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int yr);
    case (mo)
      2: return (yr % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    int h12;
    case (k)
      0: return bcd(e_sec);
      1: return bcd(e_min);
      2: begin
        if (e_m12 != 0) begin
          h12 = (e_hr % 12 == 0) ? 12 : e_hr % 12;
          return 8'h40 | ((e_hr >= 12) ? 8'h20 : 8'h00) | bcd(h12);
        end
        return bcd(e_hr);
      end
      3: return bcd(e_dow);
      4: return bcd(e_date);
      5: return bcd(e_mon) | ((e_cent != 0) ? 8'h80 : 8'h00);
      default: return bcd(e_year);
    endcase
  endfunction

  task automatic model_tick();
    e_sec++;
    if (e_sec == 60) begin
      e_sec = 0; e_min++;
      if (e_min == 60) begin
        e_min = 0; e_hr++;
        if (e_hr == 24) begin
          e_hr = 0;
          e_dow = (e_dow == 7) ? 1 : e_dow + 1;
          e_date++;
          if (e_date > days_in(e_mon, e_year)) begin
            e_date = 1; e_mon++;
            if (e_mon == 13) begin
              e_mon = 1; e_year++;
              if (e_year == 100) begin e_year = 0; e_cent ^= 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_dut();
    for (int k = 0; k < 7; k++) wr_byte(k, exp_byte(k));
  endtask

  task automatic run_enables(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic run_secs(input int n);
    run_enables(n * PER_SEC);
    for (int i = 0; i < n; i++) model_tick();
  endtask

  task automatic take_snap();
    @(negedge clk);
    snap_start = 1'b1;
    @(negedge clk);
    snap_start = 1'b0;
  endtask

  task automatic read_byte(input int a, output logic [7:0] v);
    rd_set = 1'b1; rd_addr = 3'(a);
    @(negedge clk);
    rd_set = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic read_all();
    take_snap();
    for (int k = 0; k < 7; k++) read_byte(k, rb[k]);
  endtask

  task automatic check_all(input string tag);
    read_all();
    for (int k = 0; k < 7; k++) chk(rb[k], exp_byte(k), tag);
  endtask

  task automatic set_time(input int m12, input int hr, input int mi, input int s,
                          input int dw, input int dt, input int mo, input int yr, input int ce);
    e_m12 = m12; e_hr = hr; e_min = mi; e_sec = s; e_dow = dw;
    e_date = dt; e_mon = mo; e_year = yr; e_cent = ce;
    load_dut();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: power-up values
    e_sec = 0; e_min = 0; e_hr = 0; e_m12 = 0; e_dow = 1; e_date = 1; e_mon = 1;
    e_year = 0; e_cent = 0;
    check_all("R1 reset");

    // R2 R3 R5: end of day in 24-hour format, weekday 7 -> 1
    set_time(0, 23, 59, 58, 7, 10, 3, 21, 0);
    run_secs(2);
    check_all("R2/R3/R5 24h midnight");

    // R4: 11 AM -> 12 PM, 12 PM -> 1 PM, 11 PM -> 12 AM with new day
    set_time(1, 11, 59, 59, 2, 5, 6, 30, 0);
    run_secs(1);
    check_all("R4 11AM to 12PM");
    set_time(1, 12, 59, 59, 2, 5, 6, 30, 0);
    run_secs(1);
    check_all("R4 12PM to 1PM");
    set_time(1, 23, 59, 59, 4, 5, 6, 30, 0);
    run_secs(1);
    check_all("R4 11PM to 12AM");

    // R6: month lengths and leap years
    set_time(0, 23, 59, 59, 1, 28, 2, 24, 0);
    run_secs(1);
    check_all("R6 Feb28 leap");
    set_time(0, 23, 59, 59, 1, 28, 2, 23, 0);
    run_secs(1);
    check_all("R6 Feb28 common");
    set_time(0, 23, 59, 59, 1, 29, 2, 0, 1);
    run_secs(1);
    check_all("R6 Feb29 year00");
    set_time(0, 23, 59, 59, 1, 30, 4, 15, 0);
    run_secs(1);
    check_all("R6 Apr30");
    set_time(0, 23, 59, 59, 1, 30, 1, 15, 0);
    run_secs(1);
    check_all("R6 Jan30");

    // R7: year 99 -> 00 toggles century
    set_time(0, 23, 59, 59, 6, 31, 12, 99, 0);
    run_secs(1);
    check_all("R7 century wrap");

    // R8: seconds write restarts the divider
    set_time(0, 8, 15, 20, 3, 12, 7, 41, 0);
    run_enables(PER_SEC - 1);
    read_all();
    chk(rb[0], bcd(20), "R8 no step before full period");
    run_enables(1);
    read_all();
    chk(rb[0], bcd(21), "R8 step after full period");

    // R9: square wave phase after a seconds write
    wr_byte(0, 8'h30);
    chk({7'd0, sqw_1hz}, 8'h00, "R9 low after write");
    run_enables(PER_SEC / 2 - 1);
    chk({7'd0, sqw_1hz}, 8'h00, "R9 still low before half");
    run_enables(1);
    chk({7'd0, sqw_1hz}, 8'h01, "R9 high at half");

    // R10: snapshot holds while live time moves
    set_time(0, 9, 0, 10, 1, 1, 1, 50, 0);
    take_snap();
    run_secs(3);
    read_byte(0, v);
    chk(v, bcd(10), "R10 snapshot stays");
    // R11: pointer wrap from byte 6 reloads snapshot
    read_byte(6, v);
    chk(v, bcd(50), "R11 byte 6 read");
    rd_next = 1'b1;
    @(negedge clk);
    rd_next = 1'b0;
    @(negedge clk);
    chk(rd_data, bcd(13), "R11 wrap refresh");

    // Random near-boundary sequences
    for (int it = 0; it < 40; it++) begin
      int mo, yr, hr;
      mo = 1 + int'($urandom % 12);
      yr = int'($urandom % 100);
      case ($urandom % 4)
        0: hr = 23;
        1: hr = 11;
        2: hr = 12;
        default: hr = int'($urandom % 24);
      endcase
      set_time(int'($urandom % 2), hr, ($urandom % 2 == 0) ? 59 : int'($urandom % 60),
               58 + int'($urandom % 2), 1 + int'($urandom % 7),
               days_in(mo, yr) - int'($urandom % 2), mo, yr, int'($urandom % 2));
      run_secs(1 + int'($urandom % 3));
      check_all("R2/R3/R4/R5/R6/R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule